// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block runs one successive-approximation conversion at a time for an external sample-and-compare front end. Software programs a settling count, then writes the control register with the power bit, a channel number and optionally the interrupt enable. The block drives the channel select and power enable pins, waits the programmed number of converter ticks, and then resolves the result one bit per tick, most significant bit first. For each bit it presents a trial code to an external DAC and reads back one comparator bit.

When the last bit resolves, the result is stored right-aligned in the data register, the busy flag drops and the interrupt status is raised. Writing zero to the control register clears the status and removes power. The same write, or any control write with the power bit low, aborts a conversion in progress. The converter clock is represented by a one-cycle enable pulse, `conv_tick`, in the bus clock domain.

Top module: `sar_ctl`

## Requirements
- R1: After reset the data, status, control and delay registers all read zero, and `pwr_en`, `irq` and `trial_code` are zero.
- R2: Reads decode the byte offset: 0x0 is the result, right-aligned with zeros above bit RES-1 and unaffected by writes; 0x4 holds busy at bit 0; 0x8 holds channel in [2:0], power in bit 3, interrupt enable in bit 5 and interrupt status in bit 6; 0xC holds the 6-bit settling count in [5:0]. All other bits read zero.
- R3: A control write with bit 3 set starts a conversion, and busy reads 1 from the next cycle.
- R4: A conversion consumes exactly D + RES converter ticks while busy, where D is the settling count (D = 0 means no settling), and `trial_code` stays zero until settling ends.
- R5: Bits resolve from the MSB down, and a trial bit is kept when `cmp_in` is high. With a comparator that reports input >= trial code, the result equals the input value. The data register changes only when a conversion completes.
- R6: On completion busy clears, interrupt status is set, and `irq` equals interrupt status AND interrupt enable.
- R7: Writing 0 to the control register clears interrupt status and drives `pwr_en` and `irq` low on the next cycle.
- R8: A control write with bit 3 clear during a conversion stops it on the next cycle. The data register keeps its previous value and interrupt status stays clear.
- R9: `ch_sel` and `pwr_en` follow the channel field and power bit of the control register, and they change only on a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_tick | input | 1 | Converter clock enable, one pulse per converter period |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| cmp_in | input | 1 | Comparator: high when input >= trial code |
| ch_sel | output | 3 | Analog channel select |
| pwr_en | output | 1 | Converter power enable |
| trial_code | output | RES | Code presented to the external DAC |
| irq | output | 1 | Interrupt request |

## Verification
Conversions are run with input values at zero, at full scale, at alternating bit patterns and at random values. Zero and full scale show whether the first and last bits are resolved. The alternating patterns catch a wrong bit order or a wrong keep/clear decision. The settling count is swept across zero, one, the maximum 63 and random values, and the ticks seen while busy are counted, which separates an off-by-one in settling from one in the bit count. Aborts during settling and during the bit phase show whether a stopped run leaves the previous result and status untouched.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int ADDR_W = 4;
  localparam int DW     = 32;
  localparam int CH_W   = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_DLY  = 4'hC;

  // control field positions, decoded by the software driver
  localparam int B_PWR = 3;
  localparam int B_IE  = 5;
  localparam int B_IS  = 6;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2
  } sar_st_e;

  typedef struct packed {
    logic            is;
    logic            ie;
    logic            pwr;
    logic [CH_W-1:0] ch;
  } ctrl_t;
endpackage

// File: rtl/sar_settle.sv
module sar_settle #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic             expire
);
  localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

  logic [DLY_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)
      cnt_n = load_val;
    else if (run && tick && (cnt_q != '0))
      cnt_n = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expire = run && tick && (cnt_q == ONE);
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int RES   = 10,
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             abort,
  input  logic [DLY_W-1:0] dly,
  input  logic             cmp_in,
  output logic             busy,
  output logic [RES-1:0]   trial_code,
  output logic             done,
  output logic [RES-1:0]   result
);
  localparam logic [RES-1:0] MSB = {1'b1, {(RES-1){1'b0}}};

  sar_st_e        st_q, st_n;
  logic [RES-1:0] acc_q, acc_n;
  logic [RES-1:0] mask_q, mask_n;
  logic           settle_exp;

  sar_settle #(.DLY_W(DLY_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (dly),
    .run      (st_q == ST_SETTLE),
    .tick     (tick),
    .expire   (settle_exp)
  );

  always_comb begin
    st_n   = st_q;
    acc_n  = acc_q;
    mask_n = mask_q;
    done   = 1'b0;
    result = acc_q;
    if (start) begin
      acc_n  = '0;
      mask_n = MSB;
      st_n   = (dly == '0) ? ST_CONV : ST_SETTLE;
    end else if (abort) begin
      acc_n  = '0;
      mask_n = '0;
      st_n   = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_SETTLE: if (settle_exp) st_n = ST_CONV;
        ST_CONV: begin
          if (tick) begin
            acc_n  = cmp_in ? (acc_q | mask_q) : acc_q;
            mask_n = mask_q >> 1;
            if (mask_q[0]) begin
              done   = 1'b1;
              result = acc_n;
              st_n   = ST_IDLE;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      acc_q  <= '0;
      mask_q <= '0;
    end else begin
      st_q   <= st_n;
      acc_q  <= acc_n;
      mask_q <= mask_n;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign trial_code = (st_q == ST_CONV) ? (acc_q | mask_q) : '0;
endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
#(
  parameter int RES   = 10,
  parameter int DLY_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [RES-1:0]    result,
  output ctrl_t             ctrl,
  output logic [DLY_W-1:0]  dly,
  output logic [RES-1:0]    data,
  output logic              start,
  output logic              abort
);
  ctrl_t            ctrl_q, ctrl_n;
  logic [DLY_W-1:0] dly_q, dly_n;
  logic [RES-1:0]   data_q, data_n;
  logic             wr_ctrl, wr_dly;

  assign wr_ctrl = bus_sel && bus_we && (bus_addr == OFS_CTRL);
  assign wr_dly  = bus_sel && bus_we && (bus_addr == OFS_DLY);
  assign start   = wr_ctrl && bus_wdata[B_PWR];
  assign abort   = wr_ctrl && !bus_wdata[B_PWR];

  always_comb begin
    ctrl_n = ctrl_q;
    dly_n  = dly_q;
    data_n = data_q;
    if (wr_ctrl) begin
      ctrl_n.ch  = bus_wdata[CH_W-1:0];
      ctrl_n.pwr = bus_wdata[B_PWR];
      ctrl_n.ie  = bus_wdata[B_IE];
      ctrl_n.is  = 1'b0;
    end else if (done) begin
      ctrl_n.is  = 1'b1;
    end
    if (done) data_n = result;
    if (wr_dly) dly_n = bus_wdata[DLY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dly_q  <= '0;
      data_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      dly_q  <= dly_n;
      data_q <= data_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_DATA: bus_rdata[RES-1:0] = data_q;
      OFS_STAT: bus_rdata[0] = busy;
      OFS_CTRL: begin
        bus_rdata[CH_W-1:0] = ctrl_q.ch;
        bus_rdata[B_PWR]    = ctrl_q.pwr;
        bus_rdata[B_IE]     = ctrl_q.ie;
        bus_rdata[B_IS]     = ctrl_q.is;
      end
      OFS_DLY:  bus_rdata[DLY_W-1:0] = dly_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign dly  = dly_q;
  assign data = data_q;
endmodule

// File: rtl/sar_ctl.sv
module sar_ctl
  import sar_pkg::*;
#(
  parameter int RES   = 10,
  parameter int DLY_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              cmp_in,
  output logic [CH_W-1:0]   ch_sel,
  output logic              pwr_en,
  output logic [RES-1:0]    trial_code,
  output logic              irq
);
  logic             rst_m, rst_s;
  logic             busy, done, start, abort;
  logic [RES-1:0]   result, data_q;
  logic [DLY_W-1:0] dly;
  ctrl_t            ctrl;
  logic             int_st;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  sar_regs #(.RES(RES), .DLY_W(DLY_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .ctrl      (ctrl),
    .dly       (dly),
    .data      (data_q),
    .start     (start),
    .abort     (abort)
  );

  sar_engine #(.RES(RES), .DLY_W(DLY_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_s),
    .tick       (conv_tick),
    .start      (start),
    .abort      (abort),
    .dly        (dly),
    .cmp_in     (cmp_in),
    .busy       (busy),
    .trial_code (trial_code),
    .done       (done),
    .result     (result)
  );

  assign int_st = ctrl.is;
  assign ch_sel = ctrl.ch;
  assign pwr_en = ctrl.pwr;
  assign irq    = ctrl.is && ctrl.ie;
endmodule

// File: rtl/sar_chk.sv
module sar_chk
  import sar_pkg::*;
#(
  parameter int RES = 10
) (
  input logic              clk,
  input logic              rst_s,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              busy,
  input logic              pwr_en,
  input logic              irq,
  input logic [CH_W-1:0]   ch_sel,
  input logic [RES-1:0]    data_q,
  input logic              int_st
);
  logic wr_c;
  assign wr_c = bus_sel && bus_we && (bus_addr == OFS_CTRL);

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_s)
    wr_c && bus_wdata[B_PWR] |=> busy);

  assert_data_only_on_done_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(data_q) |-> $past(busy));

  assert_done_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(busy) && pwr_en |-> int_st);

  assert_zero_write_off_R7: assert property (@(posedge clk) disable iff (!rst_s)
    wr_c && (bus_wdata == '0) |=> !pwr_en && !irq && !int_st);

  assert_abort_keeps_data_R8: assert property (@(posedge clk) disable iff (!rst_s)
    busy && wr_c && !bus_wdata[B_PWR] |=> !busy && $stable(data_q) && !int_st);

  assert_chsel_stable_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !wr_c |=> $stable(ch_sel) && $stable(pwr_en));
endmodule

bind sar_ctl sar_chk #(.RES(RES)) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .busy      (busy),
  .pwr_en    (pwr_en),
  .irq       (irq),
  .ch_sel    (ch_sel),
  .data_q    (data_q),
  .int_st    (int_st)
);

// File: tb/sim_sar_ctl.sv
`timescale 1ns/1ps
module sim_sar_ctl;
  localparam int RES = 10;
  localparam int TDIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [RES-1:0] trial_code;
  logic [2:0]  ch_sel;
  logic        pwr_en, irq, cmp_in;
  logic [RES-1:0] vin = '0;
  int checks = 0, fails = 0, cyc = 0, tdiv = 0;
  logic [RES-1:0] last_res = '0;

  always #2 clk = ~clk;

  assign cmp_in = (vin >= trial_code);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tdiv <= (tdiv == TDIV-1) ? 0 : tdiv + 1;
    tick <= (tdiv == TDIV-1);
    if (cyc == 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  sar_ctl #(.RES(RES), .DLY_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_tick(tick),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
    .ch_sel(ch_sel), .pwr_en(pwr_en), .trial_code(trial_code), .irq(irq)
  );

  function automatic int exp_ticks(input int d);
    return d + RES;
  endfunction

  function automatic logic [31:0] exp_ctrl(input int ch, input int pwr, input int ie, input int is_);
    return 32'(ch) | (32'(pwr) << 3) | (32'(ie) << 5) | (32'(is_) << 6);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic convert(input int ch, input int ie, input int d, input logic [RES-1:0] v);
    logic [31:0] r;
    int n = 0, guard = 0;
    vin = v;
    wr(4'hC, 32'(d));
    wr(4'h8, exp_ctrl(ch, 1, ie, 0));
    rd(4'h4, r);
    chk("R3 busy after start", r, 32'd1);
    chk("R9 ch_sel", 32'(ch_sel), 32'(ch));
    while (u0_busy_port(r) && guard < 5000) begin
      if (tick) n++;
      @(negedge clk);
      rd(4'h4, r);
      guard++;
    end
    chk("R4 ticks while busy", 32'(n), 32'(exp_ticks(d)));
    rd(4'h0, r);
    chk("R5 result", r, 32'(v));
    rd(4'h8, r);
    chk("R6 status set", r, exp_ctrl(ch, 1, ie, 1));
    chk("R6 irq", 32'(irq), 32'(ie));
    last_res = v;
    wr(4'h8, 32'd0);
    chk("R7 pwr_en low", 32'(pwr_en), 32'd0);
    chk("R7 irq low", 32'(irq), 32'd0);
    rd(4'h8, r);
    chk("R7 ctrl cleared", r, 32'd0);
  endtask

  function automatic logic u0_busy_port(input logic [31:0] s);
    return s[0];
  endfunction

  task automatic abort_after(input int d, input int wait_cyc, input logic [RES-1:0] v);
    logic [31:0] r;
    vin = v;
    wr(4'hC, 32'(d));
    wr(4'h8, exp_ctrl(2, 1, 1, 0));
    repeat (wait_cyc) @(negedge clk);
    rd(4'h4, r);
    chk("R8 still busy before abort", r, 32'd1);
    wr(4'h8, exp_ctrl(2, 0, 1, 0));
    rd(4'h4, r);
    chk("R8 idle after abort", r, 32'd0);
    repeat (40) @(negedge clk);
    rd(4'h0, r);
    chk("R8 data kept", r, 32'(last_res));
    rd(4'h8, r);
    chk("R8 no status", r, exp_ctrl(2, 0, 1, 0));
    chk("R8 irq low", 32'(irq), 32'd0);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(4'h0, r); chk("R1 data", r, 0);
    rd(4'h4, r); chk("R1 status", r, 0);
    rd(4'h8, r); chk("R1 ctrl", r, 0);
    rd(4'hC, r); chk("R1 delay", r, 0);
    chk("R1 pins", {29'd0, pwr_en, irq, |trial_code}, 0);
    // R2 decode and field widths
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, r); chk("R2 delay width", r, 32'h3F);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, r); chk("R2 data read-only", r, 0);
    // R9 channel without power, no start
    wr(4'h8, exp_ctrl(5, 0, 0, 0) | 32'hFFFF_FF90 & ~32'h68);
    rd(4'h8, r); chk("R2 ctrl unused bits", r, exp_ctrl(5, 0, 0, 0));
    chk("R9 ch_sel follows", 32'(ch_sel), 5);
    rd(4'h4, r); chk("R3 no start without power", r, 0);
    repeat (3) @(negedge clk);
    chk("R9 ch_sel stable", 32'(ch_sel), 5);
    // directed corners
    convert(0, 1, 0, '0);
    convert(7, 1, 1, '1);
    convert(3, 0, 63, 10'h2AA);
    convert(4, 1, 8, 10'h155);
    convert(1, 1, 2, 10'h200);
    convert(6, 0, 0, 10'h1FF);
    // R4 trial code zero during settling
    vin = 10'h3FF;
    wr(4'hC, 32'd20);
    wr(4'h8, exp_ctrl(0, 1, 0, 0));
    repeat (5) @(negedge clk);
    chk("R4 trial zero in settle", 32'(trial_code), 0);
    wr(4'h8, 32'd0);
    // aborts in settle and in the bit phase
    abort_after(30, 6, 10'h123);
    abort_after(0, 12, 10'h321);
    // random
    for (int i = 0; i < 24; i++) begin
      convert(int'($urandom_range(7)), int'($urandom_range(1)),
              int'($urandom_range(15)), RES'($urandom_range((1 << RES) - 1)));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule